// File: doc/BRIEF.md
# BCD Countdown Timer with End-of-Count Warning

This block keeps a countdown value as three packed-BCD fields (hours, minutes, seconds) inside a digital clock. The value is loaded one field at a time. A cursor strobe picks the field, and up/down adjust levels then step that field once per 1 Hz tick. When the run level is high, every tick takes one second off the value. A borrow ripples from seconds into minutes and from minutes into hours. When run is low, the value stays as it is.

The block does not roll over past zero. When the count reaches 00:00:00 it stays there and raises a done flag. During the last stretch of the count (ten seconds by default) it asserts a beep request for an external tone generator. A field adjustment in the same tick always wins over the countdown, and it also clears the done flag. Everything runs on one clock, and `tick_1hz` is a one-cycle enable pulse in that clock domain.

Top module: `bcd_countdown_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, all three fields become 8'h00 and `done` becomes 0. No field is selected afterwards, so adjust levels have no effect until the first cursor strobe.
- R2: Each field is packed BCD, tens digit in bits [7:4] and ones digit in bits [3:0]. Hours stay within 00..23 and minutes and seconds within 00..59.
- R3: A `field_next` pulse moves the cursor. From the unselected state it goes to hours, then to minutes, then to seconds, then back to hours.
- R4: On a tick with `adj_up` high, the selected field steps up by one and wraps from its maximum to 00. With `adj_dn` high it steps down by one and wraps from 00 to its maximum. `adj_up` wins when both are high. The other fields do not change.
- R5: On a tick with `run` high and no adjustment, the value goes down by one second. A ones digit at 0 becomes 9 and borrows from its tens digit. A seconds or minutes tens digit at 0 becomes 5 and borrows from the next field up.
- R6: On a tick with `run` low and no adjustment, all fields keep their values.
- R7: The countdown never goes below 00:00:00. On a running tick that reaches zero, or a running tick taken at zero, `done` is set. At zero the value is held.
- R8: Any adjustment step clears `done` in the same cycle.
- R9: `beep_req` is high exactly when `run` is high, hours and minutes are 00, seconds are below 10, and `done` is low.
- R10: When an adjustment happens on a tick, no countdown step is taken in that tick, even with `run` high.
- R11: No field changes in a cycle without a tick, except through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| run | input | 1 | Count down while high |
| field_next | input | 1 | Pulse that moves the adjust cursor |
| adj_up | input | 1 | Step the selected field up on the tick |
| adj_dn | input | 1 | Step the selected field down on the tick |
| hours_bcd | output | 8 | Hours, packed BCD |
| minutes_bcd | output | 8 | Minutes, packed BCD |
| seconds_bcd | output | 8 | Seconds, packed BCD |
| beep_req | output | 1 | Warning request for the tone generator |
| done | output | 1 | Countdown reached zero |

## Verification
The hardest state to reach is a borrow that crosses two fields at once, such as 01:00:00 becoming 00:59:59. The bench gets there by walking the cursor to hours and then seconds to load 01:00:05, and then runs with idle cycles between ticks. The same loading path sets up 00:00:12 and runs the count through the warning window into the held zero state. There an adjust tick taken with `run` still high has to clear `done`. A long random phase with sparse cursor strobes and occasional resets then mixes adjustments and countdown ticks against the behavioural model.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

   localparam int DIGIT_W = 4;
   localparam int FIELD_W = 2 * DIGIT_W;

   typedef logic [FIELD_W-1:0] bcd2_t;

   // One step up with wrap from top to zero
   function automatic bcd2_t bcd_step_up(bcd2_t v, bcd2_t top);
      bcd2_t r;
      if (v == top)
         r = '0;
      else if (v[3:0] == 4'd9)
         r = {v[7:4] + 4'd1, 4'd0};
      else
         r = {v[7:4], v[3:0] + 4'd1};
      return r;
   endfunction

   // One step down with wrap from zero to top
   function automatic bcd2_t bcd_step_dn(bcd2_t v, bcd2_t top);
      bcd2_t r;
      if (v == '0)
         r = top;
      else if (v[3:0] == 4'd0)
         r = {v[7:4] - 4'd1, 4'd9};
      else
         r = {v[7:4], v[3:0] - 4'd1};
      return r;
   endfunction

   function automatic logic [6:0] bcd_to_bin(bcd2_t v);
      return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
   endfunction

endpackage

// File: rtl/cdt_bcd_field.sv
module cdt_bcd_field
   import cdt_pkg::*;
#(
   parameter bcd2_t TOP_BCD = 8'h59
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  adj_en,
   input  logic  adj_up,
   input  logic  borrow_in,
   output bcd2_t value,
   output logic  is_zero
);

   if (TOP_BCD[3:0] > 4'd9 || TOP_BCD[7:4] > 4'd9) begin : g_bad_top
      $error("cdt_bcd_field: TOP_BCD must be valid packed BCD");
   end

   bcd2_t val_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         val_q <= '0;
      else if (adj_en)
         val_q <= adj_up ? bcd_step_up(val_q, TOP_BCD) : bcd_step_dn(val_q, TOP_BCD);
      else if (borrow_in)
         val_q <= bcd_step_dn(val_q, TOP_BCD);
   end

   assign value   = val_q;
   assign is_zero = (val_q == '0);

endmodule

// File: rtl/cdt_field_cursor.sv
module cdt_field_cursor #(
   parameter int N_FIELDS = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                step,
   output logic [N_FIELDS-1:0] sel
);

   if (N_FIELDS < 2) begin : g_bad_n
      $error("cdt_field_cursor: at least two fields are required");
   end

   logic [N_FIELDS-1:0] sel_q;

   // Most significant field first, then rotate toward bit 0 and wrap
   always_ff @(posedge clk) begin
      if (!rst_n)
         sel_q <= '0;
      else if (step) begin
         if (sel_q == '0)
            sel_q <= {1'b1, {(N_FIELDS-1){1'b0}}};
         else
            sel_q <= {sel_q[0], sel_q[N_FIELDS-1:1]};
      end
   end

   assign sel = sel_q;

endmodule

// File: rtl/cdt_run_ctl.sv
module cdt_run_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic run,
   input  logic adjust_req,
   input  logic all_zero,
   input  logic at_one,
   output logic count_en,
   output logic done
);

   logic done_q;
   logic run_tick;

   assign run_tick = tick & run & ~adjust_req;
   assign count_en = run_tick & ~all_zero;

   always_ff @(posedge clk) begin
      if (!rst_n)
         done_q <= 1'b0;
      else if (adjust_req)
         done_q <= 1'b0;
      else if (run_tick && (all_zero || at_one))
         done_q <= 1'b1;
   end

   assign done = done_q;

endmodule

// File: rtl/bcd_countdown_timer.sv
module bcd_countdown_timer
   import cdt_pkg::*;
#(
   parameter logic [7:0] HOUR_TOP_BCD   = 8'h23,
   parameter logic [7:0] MINSEC_TOP_BCD = 8'h59,
   parameter int         WARN_SECS      = 10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_1hz,
   input  logic       run,
   input  logic       field_next,
   input  logic       adj_up,
   input  logic       adj_dn,
   output logic [7:0] hours_bcd,
   output logic [7:0] minutes_bcd,
   output logic [7:0] seconds_bcd,
   output logic       beep_req,
   output logic       done
);

   localparam int N_FIELDS = 3;
   localparam int SEC_IDX  = 0;
   localparam int MIN_IDX  = 1;
   localparam int HOUR_IDX = 2;

   if (WARN_SECS < 1 || WARN_SECS > 60) begin : g_bad_warn
      $error("bcd_countdown_timer: WARN_SECS must lie in 1..60");
   end
   if (HOUR_TOP_BCD[3:0] > 4'd9 || MINSEC_TOP_BCD > 8'h59) begin : g_bad_tops
      $error("bcd_countdown_timer: field maxima must be valid BCD");
   end

   logic [N_FIELDS-1:0] sel_onehot;
   logic [N_FIELDS-1:0] zero_vec;
   logic [N_FIELDS-1:0] borrow_vec;
   bcd2_t               field_val [N_FIELDS];
   logic                adjust_req;
   logic                count_en;
   logic                all_zero;
   logic                at_one;
   logic                in_window;
   logic                done_q;

   cdt_field_cursor #(.N_FIELDS(N_FIELDS)) u_cursor (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (field_next),
      .sel   (sel_onehot)
   );

   assign adjust_req = tick_1hz & (adj_up | adj_dn) & (|sel_onehot);

   for (genvar i = 0; i < N_FIELDS; i++) begin : g_field
      localparam bcd2_t TOP = (i == HOUR_IDX) ? HOUR_TOP_BCD : MINSEC_TOP_BCD;
      if (i == 0) begin : g_head
         assign borrow_vec[i] = count_en;
      end else begin : g_link
         assign borrow_vec[i] = borrow_vec[i-1] & zero_vec[i-1];
      end
      cdt_bcd_field #(.TOP_BCD(TOP)) u_field (
         .clk       (clk),
         .rst_n     (rst_n),
         .adj_en    (adjust_req & sel_onehot[i]),
         .adj_up    (adj_up),
         .borrow_in (borrow_vec[i]),
         .value     (field_val[i]),
         .is_zero   (zero_vec[i])
      );
   end

   assign all_zero = &zero_vec;
   assign at_one   = zero_vec[HOUR_IDX] & zero_vec[MIN_IDX] & (field_val[SEC_IDX] == 8'h01);

   cdt_run_ctl u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick_1hz),
      .run        (run),
      .adjust_req (adjust_req),
      .all_zero   (all_zero),
      .at_one     (at_one),
      .count_en   (count_en),
      .done       (done_q)
   );

   // Whole tens: compare the tens digit only; otherwise convert to binary
   if (WARN_SECS % 10 == 0) begin : g_warn_tens
      assign in_window = field_val[SEC_IDX][7:4] < 4'(WARN_SECS / 10);
   end else begin : g_warn_bin
      assign in_window = bcd_to_bin(field_val[SEC_IDX]) < 7'(WARN_SECS);
   end

   assign beep_req    = run & zero_vec[HOUR_IDX] & zero_vec[MIN_IDX] & in_window & ~done_q;
   assign done        = done_q;
   assign hours_bcd   = field_val[HOUR_IDX];
   assign minutes_bcd = field_val[MIN_IDX];
   assign seconds_bcd = field_val[SEC_IDX];

endmodule

// File: rtl/cdt_checker.sv
module cdt_checker #(
   parameter logic [7:0] HOUR_TOP = 8'h23
) (
   input logic       clk,
   input logic       rst_n,
   input logic       tick,
   input logic       run,
   input logic       adj_up,
   input logic       adj_dn,
   input logic [2:0] sel,
   input logic [7:0] hours,
   input logic [7:0] minutes,
   input logic [7:0] seconds,
   input logic       beep,
   input logic       done
);

   logic adj_now;
   logic zero_now;
   assign adj_now  = tick && (adj_up || adj_dn) && (sel != 3'b000);
   assign zero_now = (hours == 8'h00) && (minutes == 8'h00) && (seconds == 8'h00);

   // R2
   hours_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hours <= HOUR_TOP) && (hours[3:0] <= 4'd9));

   // R2
   minsec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (minutes <= 8'h59) && (seconds <= 8'h59) && (minutes[3:0] <= 4'd9) && (seconds[3:0] <= 4'd9));

   // R11
   no_tick_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(hours) && $stable(minutes) && $stable(seconds));

   // R6
   halted_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !run && !adj_now) |=> $stable(hours) && $stable(minutes) && $stable(seconds));

   // R5
   ones_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && run && !adj_now && seconds[3:0] != 4'd0) |=> (seconds[3:0] == $past(seconds[3:0]) - 4'd1));

   // R7
   done_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> zero_now);

   // R7
   zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && run && !adj_now && zero_now) |=> zero_now && done);

   // R8
   done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adj_now |=> !done);

   // R9
   beep_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      beep |-> run && !done && hours == 8'h00 && minutes == 8'h00);

   // R10
   adjust_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adj_now && !sel[0]) |=> $stable(seconds));

endmodule

bind bcd_countdown_timer cdt_checker #(.HOUR_TOP(HOUR_TOP_BCD)) u_cdt_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .tick    (tick_1hz),
   .run     (run),
   .adj_up  (adj_up),
   .adj_dn  (adj_dn),
   .sel     (sel_onehot),
   .hours   (hours_bcd),
   .minutes (minutes_bcd),
   .seconds (seconds_bcd),
   .beep    (beep_req),
   .done    (done)
);

// File: tb/test_bcd_countdown_timer.sv
module test_bcd_countdown_timer;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_1hz = 1'b0;
   logic       run = 1'b0;
   logic       field_next = 1'b0;
   logic       adj_up = 1'b0;
   logic       adj_dn = 1'b0;
   logic [7:0] hours_bcd, minutes_bcd, seconds_bcd;
   logic       beep_req, done;

   always #2 clk = ~clk;

   bcd_countdown_timer i_bcd_countdown_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_1hz    (tick_1hz),
      .run         (run),
      .field_next  (field_next),
      .adj_up      (adj_up),
      .adj_dn      (adj_dn),
      .hours_bcd   (hours_bcd),
      .minutes_bcd (minutes_bcd),
      .seconds_bcd (seconds_bcd),
      .beep_req    (beep_req),
      .done        (done)
   );

   int    n_checks = 0;
   int    n_fails  = 0;
   string cur_req  = "R1";

   // Reference model: plain integers, cursor 0=none 1=hours 2=minutes 3=seconds
   int mh = 0, mm = 0, ms = 0, msel = 0, mdone = 0;

   function automatic logic [7:0] to_bcd(int v);
      return 8'(((v / 10) << 4) | (v % 10));
   endfunction

   task automatic check_outputs();
      logic eb;
      eb = run && mh == 0 && mm == 0 && ms < 10 && mdone == 0;
      n_checks += 3;
      if (hours_bcd !== to_bcd(mh) || minutes_bcd !== to_bcd(mm) || seconds_bcd !== to_bcd(ms)) begin
         n_fails++;
         $display("FAIL %s: time %h:%h:%h expected %h:%h:%h", cur_req,
                  hours_bcd, minutes_bcd, seconds_bcd, to_bcd(mh), to_bcd(mm), to_bcd(ms));
      end
      if (done !== (mdone != 0)) begin
         n_fails++;
         $display("FAIL R7 (%s): done %b expected %0d", cur_req, done, mdone);
      end
      if (beep_req !== eb) begin
         n_fails++;
         $display("FAIL R9 (%s): beep_req %b expected %b", cur_req, beep_req, eb);
      end
   endtask

   task automatic model_edge();
      int old_sel, lim, tot;
      if (!rst_n) begin
         mh = 0; mm = 0; ms = 0; msel = 0; mdone = 0;
         return;
      end
      old_sel = msel;
      if (field_next) msel = (msel == 0 || msel == 3) ? 1 : msel + 1;
      if (tick_1hz && (adj_up || adj_dn) && old_sel != 0) begin
         lim = (old_sel == 1) ? 24 : 60;
         case (old_sel)
            1: mh = adj_up ? (mh + 1) % lim : (mh + lim - 1) % lim;
            2: mm = adj_up ? (mm + 1) % lim : (mm + lim - 1) % lim;
            default: ms = adj_up ? (ms + 1) % lim : (ms + lim - 1) % lim;
         endcase
         mdone = 0;
      end else if (tick_1hz && run) begin
         tot = mh * 3600 + mm * 60 + ms;
         if (tot <= 1) begin
            tot = 0;
            mdone = 1;
         end else begin
            tot--;
         end
         mh = tot / 3600;
         mm = (tot / 60) % 60;
         ms = tot % 60;
      end
   endtask

   // One clock: check the previous edge's result, drive new inputs, predict the next edge
   task automatic cyc(input bit rs, input bit t, input bit r, input bit nx, input bit up, input bit dn);
      @(negedge clk);
      check_outputs();
      rst_n = rs; tick_1hz = t; run = r; field_next = nx; adj_up = up; adj_dn = dn;
      model_edge();
   endtask

   task automatic do_reset();
      cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic press_next();
      cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
   endtask

   task automatic adjust(input bit up, input bit dn, input int n);
      for (int i = 0; i < n; i++) begin
         cyc(1'b1, 1'b1, 1'b0, 1'b0, up, dn);
         cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      end
   endtask

   task automatic countdown(input bit r, input int n, input int gap);
      for (int i = 0; i < n; i++) begin
         cyc(1'b1, 1'b1, r, 1'b0, 1'b0, 1'b0);
         for (int g = 0; g < gap; g++) cyc(1'b1, 1'b0, r, 1'b0, 1'b0, 1'b0);
      end
   endtask

   initial begin
      #(4 * 150000);
      n_fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      // R1: reset state
      cur_req = "R1";
      do_reset();
      cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      // R4: nothing selected after reset, adjust has no effect
      cur_req = "R4";
      adjust(1'b1, 1'b0, 3);
      // R3: cursor walks hours, minutes, seconds, hours
      cur_req = "R3";
      press_next(); adjust(1'b1, 1'b0, 1);
      press_next(); adjust(1'b1, 1'b0, 1);
      press_next(); adjust(1'b1, 1'b0, 1);
      press_next(); adjust(1'b1, 1'b0, 1);
      // R2 and R4: hour wrap 23->00 and 00->23, up wins over down
      cur_req = "R2";
      adjust(1'b1, 1'b0, 22);
      adjust(1'b0, 1'b1, 1);
      cur_req = "R4";
      adjust(1'b1, 1'b1, 1);
      press_next(); adjust(1'b0, 1'b1, 2);
      press_next(); adjust(1'b0, 1'b1, 1); adjust(1'b1, 1'b0, 3);

      // R5: load 01:00:05 and borrow across two fields
      cur_req = "R5";
      do_reset();
      press_next(); adjust(1'b1, 1'b0, 1);
      press_next();
      press_next(); adjust(1'b1, 1'b0, 5);
      cur_req = "R11";
      countdown(1'b1, 8, 2);
      // R6: halted
      cur_req = "R6";
      countdown(1'b0, 3, 1);
      // R10: adjust on a running tick wins
      cur_req = "R10";
      cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
      cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      press_next();
      cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
      cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

      // R7 and R9: load 00:00:12, run through the window into zero
      cur_req = "R9";
      do_reset();
      press_next(); press_next(); press_next();
      adjust(1'b1, 1'b0, 12);
      countdown(1'b1, 12, 1);
      cur_req = "R7";
      countdown(1'b1, 4, 1);
      // R8: adjust while done clears it
      cur_req = "R8";
      cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
      cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      countdown(1'b1, 3, 0);

      // Mixed random phase
      cur_req = "R5";
      for (int i = 0; i < 4000; i++) begin
         cyc(($urandom % 600) != 0, ($urandom % 4) == 0, ($urandom % 5) != 0,
             ($urandom % 40) == 0, ($urandom % 9) == 0, ($urandom % 9) == 0);
      end
      cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      @(negedge clk);
      check_outputs();

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule